// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block sits beside a shared memory and arbitrates atomic read-modify-write sequences built from a load-reserved request followed by a store-conditional request. It watches one request per cycle. Each request carries an address, the ID of the hardware context that issued it, and a 2-bit kind. The block keeps a small table of reservations. Each entry holds a 16-byte-aligned granule and the context that owns it.

For every accepted request the monitor returns two combinational results in the same cycle. The first is a write enable that the memory uses to commit or drop the write. The second is a success flag for a store-conditional. Any store, plain or conditional, removes every reservation on its granule. This is how one context's write breaks the atomic sequences of all other contexts.

Top module: `lrsc_monitor`

## Requirements
- R1: A synchronous active-low reset invalidates every reservation and points the replacement pointer at entry 0.
- R2: A load-reserved request (kind 2'b01) records the address with bits [3:0] cleared, together with the requester's context ID. A later store-conditional (kind 2'b11) from the same context to that granule gives write enable 1 and success 1.
- R3: Addresses that differ only in bits [3:0] fall in the same granule and match. A difference in bit 4 or higher does not match.
- R4: A store-conditional whose granule is reserved only by another context fails, with write enable 0 and success 0. It still removes the reservations on that granule.
- R5: A plain store (kind 2'b10) always gives write enable 1 and success 0, and removes every reservation on its granule, whichever context owns it.
- R6: When no reservation is valid, a store-conditional fails at once, with write enable 0 and success 0.
- R7: A successful store-conditional removes every reservation on its granule, including reservations held by other contexts.
- R8: A new load-reserved from a context replaces that context's existing reservation, so each context holds at most one valid entry.
- R9: A load-reserved from a context with no entry takes the lowest-numbered free entry. When every entry is valid, it overwrites the entry at a round-robin pointer. The pointer starts at 0 and advances by one, wrapping, after each such overwrite.
- R10: A plain load (kind 2'b00) gives write enable 0 and success 0 and leaves the table unchanged.
- R11: The request port is always ready. Both results appear combinationally in the cycle of the accepted request and are 0 while no request is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Always 1; every valid request is accepted |
| req_kind | input | 2 | 00 load, 01 load-reserved, 10 store, 11 store-conditional |
| req_addr | input | ADDR_W | Physical byte address |
| req_ctx | input | CTX_W | Requesting hardware context ID |
| wr_en | output | 1 | Memory may perform the write of this request |
| sc_result | output | 1 | 1 when this store-conditional succeeds |

## Verification
The case that is hardest to reach from the ports is round-robin replacement in a full table. Getting there needs more distinct contexts than there are entries, each holding a live reservation on its own granule, and no store may touch any of those granules in between. The bench first resets, then has four contexts reserve four separate granules, then has two further contexts reserve. The pointer's progress is then read back through store-conditionals: the two earliest owners must fail and the four surviving owners must succeed.

// File: rtl/lrsc_pkg.sv
// Shared request encoding for the reservation monitor.
// Assumes a 2-bit kind field on the request port.
package lrsc_pkg;
    typedef enum logic [1:0] {
        REQ_LOAD  = 2'b00,
        REQ_LR    = 2'b01,
        REQ_STORE = 2'b10,
        REQ_SC    = 2'b11
    } req_kind_e;
endpackage

// File: rtl/lrsc_slot.sv
// One reservation entry: valid bit, granule and owning context.
// Assumes set_i and clr_i are never high in the same cycle.
module lrsc_slot #(
    parameter int GW    = 28,
    parameter int CTX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic             clr_i,
    input  logic [GW-1:0]    gran_i,
    input  logic [CTX_W-1:0] ctx_i,
    output logic             vld_o,
    output logic             gran_hit_o,
    output logic             ctx_hit_o
);
    logic             vld_q;
    logic [GW-1:0]    gran_q;
    logic [CTX_W-1:0] ctx_q;

    // Capture a new reservation or drop the current one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            gran_q <= '0;
            ctx_q  <= '0;
        end else if (set_i) begin
            vld_q  <= 1'b1;
            gran_q <= gran_i;
            ctx_q  <= ctx_i;
        end else if (clr_i) begin
            vld_q  <= 1'b0;
        end
    end

    // Compare the incoming request with the held reservation.
    always_comb begin
        vld_o      = vld_q;
        gran_hit_o = vld_q && (gran_q == gran_i);
        ctx_hit_o  = vld_q && (ctx_q == ctx_i);
    end

    assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !vld_o);
    assert_set_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> (vld_o && ctx_hit_o == ($past(ctx_i) == ctx_i)));
endmodule

// File: rtl/lrsc_alloc.sv
// Chooses the entry a load-reserved writes: the context's own entry first,
// then the lowest free entry, then the round-robin pointer when the table is full.
// Assumes own_i has at most one bit set.
module lrsc_alloc #(
    parameter int ENTRIES = 4,
    parameter int PTR_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_i,
    input  logic [ENTRIES-1:0] vld_i,
    input  logic [ENTRIES-1:0] own_i,
    output logic [ENTRIES-1:0] sel_o
);
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] own_idx, free_idx;
    logic             has_own, has_free, evict;

    // Find the lowest owned entry and the lowest free entry.
    always_comb begin
        has_own  = 1'b0;
        has_free = 1'b0;
        own_idx  = '0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (own_i[i]) begin
                has_own = 1'b1;
                own_idx = PTR_W'(i);
            end
            if (!vld_i[i]) begin
                has_free = 1'b1;
                free_idx = PTR_W'(i);
            end
        end
    end

    // Produce the one-hot target entry by priority.
    always_comb begin
        sel_o = '0;
        if (has_own)       sel_o[own_idx]  = 1'b1;
        else if (has_free) sel_o[free_idx] = 1'b1;
        else               sel_o[ptr_q]    = 1'b1;
    end

    assign evict = alloc_i && !has_own && !has_free;

    // Step the replacement pointer after each overwrite of a full table.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (evict)
            ptr_q <= (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end

    assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel_o) == 1);
    assert_ptr_steps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evict |=> (ptr_q != $past(ptr_q)));
    assert_ptr_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !evict |=> $stable(ptr_q));
endmodule

// File: rtl/lrsc_monitor.sv
// Reservation monitor for load-reserved / store-conditional pairs.
// Decides per request whether a write may proceed and whether a
// store-conditional succeeded; results are combinational in the request cycle.
// Assumes one request per cycle and that the port is always ready.
module lrsc_monitor
    import lrsc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int CTX_W     = 3,
    parameter int ENTRIES   = 4,
    parameter int GRAN_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CTX_W-1:0]  req_ctx,
    output logic              wr_en,
    output logic              sc_result
);
    localparam int GW    = ADDR_W - GRAN_BITS;
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    req_kind_e          kind;
    logic [GW-1:0]      gran;
    logic [ENTRIES-1:0] slot_vld, gran_hit, ctx_hit, sel, set_vec, clr_vec;
    logic               is_lr, is_any_store, sc_pass;

    // Decode the request.
    always_comb begin
        kind         = req_kind_e'(req_kind);
        gran         = req_addr[ADDR_W-1:GRAN_BITS];
        is_lr        = req_valid && (kind == REQ_LR);
        is_any_store = req_valid && ((kind == REQ_STORE) || (kind == REQ_SC));
    end

    // Form the write decision and the conditional-store result.
    always_comb begin
        req_ready = 1'b1;
        sc_pass   = |(gran_hit & ctx_hit);
        sc_result = req_valid && (kind == REQ_SC) && sc_pass;
        wr_en     = req_valid && ((kind == REQ_STORE) || ((kind == REQ_SC) && sc_pass));
        set_vec   = sel & {ENTRIES{is_lr}};
        clr_vec   = gran_hit & {ENTRIES{is_any_store}};
    end

    lrsc_alloc #(.ENTRIES(ENTRIES), .PTR_W(PTR_W)) u_alloc (
        .clk    (clk),
        .rst_n  (rst_n),
        .alloc_i(is_lr),
        .vld_i  (slot_vld),
        .own_i  (ctx_hit),
        .sel_o  (sel)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        lrsc_slot #(.GW(GW), .CTX_W(CTX_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (set_vec[g]),
            .clr_i     (clr_vec[g]),
            .gran_i    (gran),
            .ctx_i     (req_ctx),
            .vld_o     (slot_vld[g]),
            .gran_hit_o(gran_hit[g]),
            .ctx_hit_o (ctx_hit[g])
        );
    end

    assert_empty_sc_fails_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'b11 && slot_vld == '0) |-> (!wr_en && !sc_result));
    assert_store_writes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'b10) |-> (wr_en && !sc_result));
    assert_load_keeps_table_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'b00) |=> $stable(slot_vld));
    assert_load_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'b00) |-> (!wr_en && !sc_result));
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!wr_en && !sc_result));
    assert_success_writes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sc_result |-> wr_en);
    assert_one_per_ctx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        is_lr |=> ($countones(ctx_hit) <= 1));
endmodule

// File: tb/tb_lrsc_monitor.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_lrsc_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'b00;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_ctx = '0;
    logic        wr_en, sc_result;
    int          nchk = 0;
    int          nerr = 0;
    bit          done = 1'b0;

    localparam logic [1:0] K_LD = 2'b00, K_LR = 2'b01, K_ST = 2'b10, K_SC = 2'b11;

    always #4 clk = ~clk;

    lrsc_monitor dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_addr(req_addr), .req_ctx(req_ctx),
        .wr_en(wr_en), .sc_result(sc_result)
    );

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic issue(input logic [1:0] k, input logic [31:0] a, input logic [2:0] c,
                         input logic exp_we, input logic exp_sc, input string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = k;
        req_addr  = a;
        req_ctx   = c;
        #1;
        nchk++;
        if (wr_en !== exp_we || sc_result !== exp_sc || req_ready !== 1'b1) begin
            nerr++;
            $display("FAIL %s: actual we=%b sc=%b rdy=%b expected we=%b sc=%b rdy=1",
                     tag, wr_en, sc_result, req_ready, exp_we, exp_sc);
        end
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic t_reset();
        issue(K_LR, 32'h100, 3'd0, 1'b0, 1'b0, "R2 lr before reset");
        do_reset();
        issue(K_SC, 32'h100, 3'd0, 1'b0, 1'b0, "R1 reservation cleared by reset");
        issue(K_SC, 32'h200, 3'd1, 1'b0, 1'b0, "R6 sc on empty table");
        @(negedge clk);
        req_valid = 1'b0;
        req_kind  = K_ST;
        #1;
        nchk++;
        if (wr_en !== 1'b0 || sc_result !== 1'b0 || req_ready !== 1'b1) begin
            nerr++;
            $display("FAIL R11 idle: actual we=%b sc=%b rdy=%b expected we=0 sc=0 rdy=1",
                     wr_en, sc_result, req_ready);
        end
    endtask

    task automatic t_basic();
        issue(K_LR, 32'h1234, 3'd1, 1'b0, 1'b0, "R2 lr");
        issue(K_SC, 32'h123C, 3'd1, 1'b1, 1'b1, "R2 R3 sc same granule");
        issue(K_SC, 32'h1234, 3'd1, 1'b0, 1'b0, "R7 second sc after success");
    endtask

    task automatic t_granule();
        issue(K_LR, 32'h2000, 3'd2, 1'b0, 1'b0, "R3 lr");
        issue(K_SC, 32'h2010, 3'd2, 1'b0, 1'b0, "R3 bit4 differs");
        issue(K_SC, 32'h200F, 3'd2, 1'b1, 1'b1, "R3 low bits differ");
    endtask

    task automatic t_cross();
        issue(K_LR, 32'h3000, 3'd3, 1'b0, 1'b0, "R4 lr");
        issue(K_SC, 32'h3004, 3'd4, 1'b0, 1'b0, "R4 foreign sc fails");
        issue(K_SC, 32'h3000, 3'd3, 1'b0, 1'b0, "R4 owner sc after foreign sc");
    endtask

    task automatic t_store();
        issue(K_ST, 32'hA000, 3'd0, 1'b1, 1'b0, "R5 store with empty table");
        issue(K_LR, 32'h4000, 3'd1, 1'b0, 1'b0, "R5 lr");
        issue(K_ST, 32'h4008, 3'd5, 1'b1, 1'b0, "R5 foreign store writes");
        issue(K_SC, 32'h4000, 3'd1, 1'b0, 1'b0, "R5 sc after store");
    endtask

    task automatic t_multi();
        issue(K_LR, 32'h5000, 3'd1, 1'b0, 1'b0, "R7 lr ctx1");
        issue(K_LR, 32'h5004, 3'd2, 1'b0, 1'b0, "R7 lr ctx2");
        issue(K_SC, 32'h5000, 3'd2, 1'b1, 1'b1, "R7 ctx2 succeeds");
        issue(K_SC, 32'h5000, 3'd1, 1'b0, 1'b0, "R7 ctx1 lost reservation");
    endtask

    task automatic t_replace();
        issue(K_LR, 32'h6000, 3'd6, 1'b0, 1'b0, "R8 first lr");
        issue(K_LR, 32'h7000, 3'd6, 1'b0, 1'b0, "R8 second lr");
        issue(K_SC, 32'h6000, 3'd6, 1'b0, 1'b0, "R8 old granule dropped");
        issue(K_SC, 32'h7000, 3'd6, 1'b1, 1'b1, "R8 new granule held");
    endtask

    task automatic t_load();
        issue(K_LR, 32'h8000, 3'd1, 1'b0, 1'b0, "R10 lr");
        issue(K_LD, 32'h8000, 3'd2, 1'b0, 1'b0, "R10 foreign load");
        issue(K_LD, 32'h8004, 3'd1, 1'b0, 1'b0, "R10 own load");
        issue(K_SC, 32'h8000, 3'd1, 1'b1, 1'b1, "R10 reservation survives loads");
    endtask

    task automatic t_full();
        do_reset();
        for (int k = 0; k < 4; k++)
            issue(K_LR, 32'h9000 + 32'(k) * 32'h10, 3'(k), 1'b0, 1'b0, "R9 fill");
        issue(K_LR, 32'h9040, 3'd4, 1'b0, 1'b0, "R9 overwrite entry 0");
        issue(K_LR, 32'h9050, 3'd5, 1'b0, 1'b0, "R9 overwrite entry 1");
        issue(K_SC, 32'h9000, 3'd0, 1'b0, 1'b0, "R9 ctx0 evicted");
        issue(K_SC, 32'h9010, 3'd1, 1'b0, 1'b0, "R9 ctx1 evicted");
        issue(K_SC, 32'h9020, 3'd2, 1'b1, 1'b1, "R9 ctx2 kept");
        issue(K_SC, 32'h9030, 3'd3, 1'b1, 1'b1, "R9 ctx3 kept");
        issue(K_SC, 32'h9040, 3'd4, 1'b1, 1'b1, "R9 ctx4 placed");
        issue(K_SC, 32'h9050, 3'd5, 1'b1, 1'b1, "R9 ctx5 placed");
    endtask

    initial begin
        do_reset();
        t_reset();
        t_basic();
        t_granule();
        t_cross();
        t_store();
        t_multi();
        t_replace();
        t_load();
        t_full();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL R11 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule